// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Arbiter

This block sits next to a small 8-bit CPU core and chooses which of four interrupt sources gets serviced next. The sources are two active-low external pins and two timer overflow strobes. Software sets a per-source enable mask, a master enable, one priority bit per source and a trigger-type bit per external pin through a small register port. The block keeps a request flag for each source and offers the CPU one winning request together with its source index, its priority level and its 16-bit vector address.

When the CPU takes the vector, it pulses the acknowledge input. The arbiter then marks that priority level as in service and clears the flag where the source type calls for it. Two in-service bits give two levels of nesting. A high-level request can interrupt a low-level routine. Nothing can interrupt a high-level routine. A return strobe closes the innermost active level. While the CPU reports a blocking instruction, or while the return strobe is high, no request is offered and an acknowledge has no effect.

Top module: `irq_arbiter2`

## Requirements
- R1: After reset the enable, priority and trigger registers read zero, no level is in service, and `irq_req` is low.
- R2: Register select codes are 0 = enable (bits 3:0 per source, bit 7 master), 1 = priority (bits 3:0), 2 = trigger type (bit 0 external 0, bit 1 external 1, 1 = edge), 3 = pending flags (read only). Source index order is external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3. A source is offered only when its enable bit and the master bit are both 1.
- R3: An eligible high-priority source (priority bit 1) wins over any low-priority one. Within one level, the lowest source index wins.
- R4: `irq_vec` equals 0x0003 + 8 × `irq_id`, which gives 0x0003, 0x000B, 0x0013 and 0x001B.
- R5: While the low level is in service, only high-priority requests are offered. While the high level is in service, no request is offered.
- R6: A return strobe clears in-service bit 1 if it is set, and otherwise clears in-service bit 0. An accepted acknowledge sets the in-service bit of the offered level (`in_service` bit 1 = high, bit 0 = low).
- R7: In edge mode, a falling edge on the synchronized pin sets the flag, and an accepted acknowledge of that source clears it. A rise on the pin does not clear it. Switching the pin to level mode drops a stored edge flag.
- R8: In level mode, the flag follows the synchronized pin (pending while low). An acknowledge does not clear it.
- R9: A timer overflow strobe sets the timer's flag, and an accepted acknowledge of that timer clears it.
- R10: While `blk_insn` or `reti` is high, `irq_req` is low and `irq_ack` changes no flag and no in-service bit. A level request that goes away before the block ends is never offered.
- R11: Writes to select code 3 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select for read and write |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read data of the selected register |
| ext_n | input | 2 | External request pins, active low, asynchronous |
| tmr_ovf | input | 2 | Timer overflow strobes, one cycle each |
| blk_insn | input | 1 | CPU reports an instruction that forbids vectoring |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_ack | input | 1 | CPU takes the offered vector |
| irq_req | output | 1 | A request is offered |
| irq_id | output | 2 | Index of the offered source |
| irq_hi | output | 1 | Offered request is high priority |
| irq_vec | output | 16 | Vector address of the offered source |
| in_service | output | 2 | In-service bits, bit 1 high level, bit 0 low level |

## Verification
The bench builds the block with its default parameters: a two-flop pin synchronizer, a vector base of 0x0003 and a stride of 8. With these values each pin change settles within four clocks and all four vector addresses can be predicted. Random mixes of register writes, pin changes in both trigger modes, timer strobes, acknowledges, returns and blocking windows drive the block into every nesting state. Together they cover both levels competing at the same time, same-level ties, and a level request that disappears inside a blocking window.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
   localparam int N_SRC   = 4;
   localparam int N_EXT   = N_SRC / 2;
   localparam int ID_W    = $clog2(N_SRC);
   localparam int CFG_W   = 8;
   localparam int GLB_BIT = CFG_W - 1;

   typedef enum logic [1:0] {
      SEL_EN   = 2'd0,
      SEL_PRI  = 2'd1,
      SEL_TRIG = 2'd2,
      SEL_PEND = 2'd3
   } cfg_sel_e;

   typedef struct packed {
      logic            valid;
      logic            hi;
      logic [ID_W-1:0] id;
   } pick_t;
endpackage

// File: rtl/irqa_src.sv
module irqa_src #(
   parameter bit IS_EXT      = 1'b1,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   input  logic edge_mode,
   input  logic take,
   output logic flag
);
   generate
      if (IS_EXT) begin : g_ext
         logic [SYNC_STAGES-1:0] sync_q;
         logic prev_q;
         logic edge_q;
         logic cur;
         logic fall;

         assign cur  = sync_q[SYNC_STAGES-1];
         assign fall = prev_q & ~cur;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_q <= '1;
               prev_q <= 1'b1;
               edge_q <= 1'b0;
            end else begin
               sync_q[0] <= raw;
               for (int k = 1; k < SYNC_STAGES; k++) begin
                  sync_q[k] <= sync_q[k-1];
               end
               prev_q <= cur;
               if (!edge_mode)  edge_q <= 1'b0;
               else if (fall)   edge_q <= 1'b1;
               else if (take)   edge_q <= 1'b0;
            end
         end

         assign flag = edge_mode ? edge_q : ~cur;
      end else begin : g_tmr
         logic hit_q;
         logic unused_mode;
         assign unused_mode = edge_mode;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     hit_q <= 1'b0;
            else if (raw)   hit_q <= 1'b1;
            else if (take)  hit_q <= 1'b0;
         end

         assign flag = hit_q;
      end
   endgenerate
endmodule

// File: rtl/irqa_pick.sv
module irqa_pick
   import irqa_pkg::*;
#(
   parameter int N = N_SRC
) (
   input  logic [N-1:0] pend,
   input  logic [N-1:0] en,
   input  logic         glb,
   input  logic [N-1:0] pri,
   input  logic [1:0]   insvc,
   input  logic         hold,
   output pick_t        win
);
   localparam int IW = $clog2(N);

   logic [N-1:0] elig, hi_c, lo_c;
   logic [IW-1:0] hi_id, lo_id;

   assign elig = pend & en & {N{glb}};
   assign hi_c = elig & pri;
   assign lo_c = elig & ~pri;

   always_comb begin
      hi_id = '0;
      lo_id = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hi_c[i]) hi_id = IW'(i);
         if (lo_c[i]) lo_id = IW'(i);
      end
   end

   always_comb begin
      win = '0;
      if (!insvc[1] && (hi_c != '0)) begin
         win.valid = 1'b1;
         win.hi    = 1'b1;
         win.id    = hi_id;
      end else if (insvc == 2'b00 && (lo_c != '0)) begin
         win.valid = 1'b1;
         win.hi    = 1'b0;
         win.id    = lo_id;
      end
      if (hold) win.valid = 1'b0;
   end
endmodule

// File: rtl/irqa_nest.sv
module irqa_nest (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       take,
   input  logic       take_hi,
   input  logic       ret,
   output logic [1:0] insvc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         insvc <= 2'b00;
      end else begin
         if (ret) begin
            if (insvc[1]) insvc[1] <= 1'b0;
            else          insvc[0] <= 1'b0;
         end
         if (take) begin
            if (take_hi) insvc[1] <= 1'b1;
            else         insvc[0] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_arbiter2.sv
module irq_arbiter2
   import irqa_pkg::*;
#(
   parameter int              SYNC_STAGES = 2,
   parameter int              VEC_W       = 16,
   parameter logic [VEC_W-1:0] VEC_BASE   = 16'h0003,
   parameter int              VEC_STEP    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_sel,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_rdata,
   input  logic [N_EXT-1:0] ext_n,
   input  logic [N_EXT-1:0] tmr_ovf,
   input  logic             blk_insn,
   input  logic             reti,
   input  logic             irq_ack,
   output logic             irq_req,
   output logic [ID_W-1:0]  irq_id,
   output logic             irq_hi,
   output logic [VEC_W-1:0] irq_vec,
   output logic [1:0]       in_service
);
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("irq_arbiter2: SYNC_STAGES must be at least 1");
   end
   if (VEC_STEP < 1) begin : g_bad_step
      $error("irq_arbiter2: VEC_STEP must be positive");
   end
   if (VEC_W < ID_W + 1) begin : g_bad_vw
      $error("irq_arbiter2: VEC_W too narrow");
   end

   cfg_sel_e          sel;
   logic [N_SRC-1:0]  en_q, pri_q, pend, take_src;
   logic              glb_q;
   logic [N_EXT-1:0]  trig_q;
   logic              take;
   pick_t             win;

   assign sel = cfg_sel_e'(cfg_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         glb_q  <= 1'b0;
         pri_q  <= '0;
         trig_q <= '0;
      end else if (cfg_we) begin
         unique case (sel)
            SEL_EN: begin
               en_q  <= cfg_wdata[N_SRC-1:0];
               glb_q <= cfg_wdata[GLB_BIT];
            end
            SEL_PRI:  pri_q  <= cfg_wdata[N_SRC-1:0];
            SEL_TRIG: trig_q <= cfg_wdata[N_EXT-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      cfg_rdata = '0;
      unique case (sel)
         SEL_EN: begin
            cfg_rdata[N_SRC-1:0] = en_q;
            cfg_rdata[GLB_BIT]   = glb_q;
         end
         SEL_PRI:  cfg_rdata[N_SRC-1:0] = pri_q;
         SEL_TRIG: cfg_rdata[N_EXT-1:0] = trig_q;
         default:  cfg_rdata[N_SRC-1:0] = pend;
      endcase
   end

   assign take = win.valid & irq_ack;

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      assign take_src[i] = take & (win.id == ID_W'(i));
      if (i % 2 == 0) begin : g_e
         irqa_src #(.IS_EXT(1'b1), .SYNC_STAGES(SYNC_STAGES)) u_src (
            .clk(clk), .rst_n(rst_n), .raw(ext_n[i/2]),
            .edge_mode(trig_q[i/2]), .take(take_src[i]), .flag(pend[i])
         );
      end else begin : g_t
         irqa_src #(.IS_EXT(1'b0), .SYNC_STAGES(SYNC_STAGES)) u_src (
            .clk(clk), .rst_n(rst_n), .raw(tmr_ovf[i/2]),
            .edge_mode(1'b0), .take(take_src[i]), .flag(pend[i])
         );
      end
   end

   irqa_pick #(.N(N_SRC)) u_pick (
      .pend(pend), .en(en_q), .glb(glb_q), .pri(pri_q),
      .insvc(in_service), .hold(blk_insn | reti), .win(win)
   );

   irqa_nest u_nest (
      .clk(clk), .rst_n(rst_n), .take(take), .take_hi(win.hi),
      .ret(reti), .insvc(in_service)
   );

   assign irq_req = win.valid;
   assign irq_id  = win.id;
   assign irq_hi  = win.hi;
   assign irq_vec = VEC_BASE + VEC_W'(VEC_STEP * int'(win.id));
endmodule

// File: rtl/irqa_chk.sv
module irqa_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       blk_insn,
   input logic       reti,
   input logic       irq_ack,
   input logic       irq_req,
   input logic [1:0] irq_id,
   input logic       irq_hi,
   input logic [15:0] irq_vec,
   input logic [1:0] in_service,
   input logic [1:0] tmr_ovf,
   input logic [3:0] pend
);
   assert_hi_blocks_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
      in_service[1] |-> !irq_req);

   assert_lo_only_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_service[0] && irq_req) |-> irq_hi);

   assert_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_insn || reti) |-> !irq_req);

   assert_block_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_insn && irq_ack && !reti) |=> $stable(in_service));

   assert_vec_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_vec[2:0] == 3'b011 && irq_vec[15:5] == '0));

   assert_ret_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && in_service == 2'b11) |=> in_service == 2'b01);

   assert_take_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_ack && irq_hi) |=> in_service[1]);

   assert_tmr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_ack && irq_id[0] && tmr_ovf == 2'b00) |=> !pend[$past(irq_id)]);
endmodule

bind irq_arbiter2 irqa_chk u_chk (
   .clk(clk), .rst_n(rst_n), .blk_insn(blk_insn), .reti(reti),
   .irq_ack(irq_ack), .irq_req(irq_req), .irq_id(irq_id), .irq_hi(irq_hi),
   .irq_vec(irq_vec), .in_service(in_service), .tmr_ovf(tmr_ovf), .pend(pend)
);

// File: tb/sim_irq_arbiter2.sv
module sim_irq_arbiter2;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [7:0]  cfg_wdata = 8'd0;
   logic [7:0]  cfg_rdata;
   logic [1:0]  ext_n = 2'b11;
   logic [1:0]  tmr_ovf = 2'b00;
   logic        blk_insn = 1'b0;
   logic        reti = 1'b0;
   logic        irq_ack = 1'b0;
   logic        irq_req;
   logic [1:0]  irq_id;
   logic        irq_hi;
   logic [15:0] irq_vec;
   logic [1:0]  in_service;

   int n_chk = 0;
   int n_bad = 0;

   // model state
   logic [3:0] m_en = 0, m_pri = 0, m_tmrf = 0;
   logic       m_glb = 0;
   logic [1:0] m_trig = 0, m_pin = 2'b11, m_edge = 0, m_isv = 0, m_tmr = 0;

   always #2 clk = ~clk;

   irq_arbiter2 u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ext_n(ext_n),
      .tmr_ovf(tmr_ovf), .blk_insn(blk_insn), .reti(reti), .irq_ack(irq_ack),
      .irq_req(irq_req), .irq_id(irq_id), .irq_hi(irq_hi), .irq_vec(irq_vec),
      .in_service(in_service)
   );

   function automatic logic [3:0] m_pend();
      logic [3:0] p;
      p[0] = m_trig[0] ? m_edge[0] : ~m_pin[0];
      p[1] = m_tmr[0];
      p[2] = m_trig[1] ? m_edge[1] : ~m_pin[1];
      p[3] = m_tmr[1];
      return p;
   endfunction

   // returns {valid, hi, id[1:0]}
   function automatic logic [3:0] m_pick();
      logic [3:0] e, h, l;
      e = m_pend() & m_en & {4{m_glb}};
      h = e & m_pri;
      l = e & ~m_pri;
      if (!m_isv[1] && h != 0) begin
         for (int i = 0; i < 4; i++) if (h[i]) return {2'b11, 2'(i)};
      end
      if (m_isv == 2'b00 && l != 0) begin
         for (int i = 0; i < 4; i++) if (l[i]) return {2'b10, 2'(i)};
      end
      return 4'b0000;
   endfunction

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic check_all(input string tag);
      logic [3:0] w;
      w = m_pick();
      cfg_sel = 2'd3;
      #1;
      chk({tag, " R2 R11 pending"}, {12'd0, cfg_rdata[3:0]}, {12'd0, m_pend()});
      chk({tag, " R3 R5 R10 req"}, {15'd0, irq_req}, {15'd0, w[3] & ~blk_insn});
      chk({tag, " R6 in_service"}, {14'd0, in_service}, {14'd0, m_isv});
      if (w[3] && !blk_insn) begin
         chk({tag, " R3 id"}, {14'd0, irq_id}, {14'd0, w[1:0]});
         chk({tag, " R3 hi"}, {15'd0, irq_hi}, {15'd0, w[2]});
         chk({tag, " R4 vec"}, irq_vec, 16'h0003 + 16'(8 * int'(w[1:0])));
      end
   endtask

   task automatic do_write(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
      case (s)
         2'd0: begin m_en = d[3:0]; m_glb = d[7]; end
         2'd1: m_pri = d[3:0];
         2'd2: begin
            m_trig = d[1:0];
            for (int k = 0; k < 2; k++) if (!m_trig[k]) m_edge[k] = 1'b0;
         end
         default: ;
      endcase
   endtask

   task automatic set_pin(input int k, input logic v);
      @(negedge clk);
      if (m_trig[k] && m_pin[k] && !v) m_edge[k] = 1'b1;
      m_pin[k] = v;
      ext_n[k] = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse_tmr(input int k);
      @(negedge clk);
      tmr_ovf[k] = 1'b1;
      @(negedge clk);
      tmr_ovf[k] = 1'b0;
      m_tmr[k] = 1'b1;
   endtask

   task automatic do_ack();
      logic [3:0] w;
      @(negedge clk);
      w = m_pick();
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      if (w[3] && !blk_insn) begin
         m_isv[w[2]] = 1'b1;
         if (w[0]) m_tmr[w[1]] = 1'b0;
         else if (m_trig[w[1]]) m_edge[w[1]] = 1'b0;
      end
   endtask

   task automatic do_reti();
      @(negedge clk);
      reti = 1'b1;
      #1;
      chk("R10 req low during return", {15'd0, irq_req}, 16'd0);
      @(negedge clk);
      reti = 1'b0;
      if (m_isv[1]) m_isv[1] = 1'b0;
      else          m_isv[0] = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int seed;
      seed = 20240611;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int s = 0; s < 3; s++) begin
         cfg_sel = 2'(s);
         #1;
         chk("R1 register reset", {8'd0, cfg_rdata}, 16'd0);
         @(negedge clk);
      end
      check_all("R1 reset");

      // R3 R4: two low timers, lower index wins
      do_write(2'd0, 8'h8F);
      pulse_tmr(0);
      pulse_tmr(1);
      check_all("R3 low tie");
      do_ack();
      check_all("R5 low in service");
      do_write(2'd1, 8'h08);
      check_all("R5 high preempts");
      do_ack();
      check_all("R5 high in service");
      do_reti();
      check_all("R6 return high");
      do_reti();
      check_all("R6 return low");

      // R2 master enable off
      pulse_tmr(0);
      do_write(2'd0, 8'h0F);
      check_all("R2 master off");
      do_write(2'd0, 8'h8D);
      check_all("R2 source off");
      do_write(2'd0, 8'h8F);
      do_ack();
      do_reti();

      // R7 edge mode on external 1
      do_write(2'd2, 8'h02);
      set_pin(1, 1'b0);
      check_all("R7 edge set");
      set_pin(1, 1'b1);
      check_all("R7 rise keeps flag");
      do_ack();
      check_all("R7 ack clears");
      do_reti();

      // R8 level mode on external 0
      set_pin(0, 1'b0);
      check_all("R8 level pending");
      do_ack();
      check_all("R8 ack keeps level");
      do_reti();

      // R10 level drops during block
      @(negedge clk);
      blk_insn = 1'b1;
      #1;
      chk("R10 blocked req", {15'd0, irq_req}, 16'd0);
      do_ack();
      check_all("R10 ack ignored");
      set_pin(0, 1'b1);
      @(negedge clk);
      blk_insn = 1'b0;
      check_all("R10 dropped request");

      // R11 write to pending select ignored
      pulse_tmr(1);
      do_write(2'd3, 8'hFF);
      check_all("R11 pending write");
      do_write(2'd3, 8'h00);
      check_all("R11 pending clear write");

      // random mix
      for (int it = 0; it < 3000; it++) begin
         int act;
         act = int'($urandom_range(0, 9));
         case (act)
            0: do_write(2'($urandom_range(0, 3)), 8'($urandom));
            1, 2: set_pin(int'($urandom_range(0, 1)), 1'($urandom));
            3: pulse_tmr(int'($urandom_range(0, 1)));
            4, 5: do_ack();
            6: do_reti();
            7: begin
               @(negedge clk);
               blk_insn = 1'b1;
               check_all("R10 random block");
               do_ack();
               @(negedge clk);
               blk_insn = 1'b0;
            end
            default: do_write(2'd0, {1'($urandom_range(0, 7) != 0), 3'd0, 4'($urandom)});
         endcase
         check_all("random");
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule